// File: doc/BRIEF.md
# Multi-channel serial audio transmitter

This block turns a stream of parallel audio samples into a three-wire serial audio stream made of bit clock, word select and serial data. The bit clock is supplied from outside and sampled in the system clock domain. Every word-select half-period, called a system word, carries between one and four data words back to back. A full frame therefore carries 2, 4, 6 or 8 channels. Samples arrive on a ready/valid input and leave the serial line in exactly the order they were accepted.

The system word may be longer than the packed data. In that case the remaining bit positions are padding. A control input places the padding either before or after the data, and another input sets the value of the padding bits.

Serial data and word select change only after a falling bit-clock edge. Word select switches one bit period before the first bit of a system word. If no sample is waiting when a data slot begins, that slot is sent as zeros and a sticky underflow flag is raised.

Top module: `mc_audio_tx`

## Requirements
- R1: Accepted words are sent in acceptance order, each MSB first. Consecutive words in a system word follow each other with no gap.
- R2: `cfg_chan` selects the number of data words per system word: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4. The frame carries twice that many channels.
- R3: When `cfg_sys_len` equals DATA_W times the words per system word, every bit of the system word is data and no padding is sent.
- R4: When the system word is longer than the packed data, `cfg_pad_first`=0 sends the data first and the padding after it. `cfg_pad_first`=1 sends the padding first and the data after it.
- R5: Every padding bit equals `cfg_pad_val`, so 1 fills with logic high and 0 with logic low.
- R6: `ws` is 0 during system word 1 and 1 during system word 2. It takes the level of the next system word while the last bit of the current system word is on `sd`.
- R7: `sd` and `ws` change only in the system clock cycle that follows the sampling of a falling `bclk` edge. They stay stable while `bclk` is high.
- R8: If the holding stage is empty when a data slot begins, the whole slot is sent as zeros and `underflow` goes high. `underflow` stays high until reset.
- R9: After a synchronous reset (`rst_n`=0), `ws`=0, `sd`=0, `underflow`=0 and `in_ready`=1. The first system word sent afterwards is system word 1.
- R10: The input has a single-word holding stage. `in_ready` is 0 while a word is held, and the stage is freed when that word's slot begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock, synchronous to clk, at most clk/2 |
| cfg_chan | input | 2 | Words per system word, minus one |
| cfg_sys_len | input | LEN_W | System word length in bits |
| cfg_pad_first | input | 1 | 1: padding before data; 0: data before padding |
| cfg_pad_val | input | 1 | Value of the padding bits |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Holding stage can accept a word |
| in_data | input | DATA_W | Input audio word |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| underflow | output | 1 | Sticky flag: a data slot started with no word available |

## Verification
The hardest situation to reach is a data slot that begins while the holding stage is empty, part-way through a frame, with words on either side of it. The bench supplies a fixed, short list of words and keeps the bit clock running past its end. The model then expects zero slots from an exact index onwards, and the sticky flag is checked at the end. The boundary between padding and data is covered by using system word lengths just above the packed data length, with both padding placements and both fill values.

// File: rtl/mc_audio_tx_pkg.sv
// Package: shared helpers for the multi-channel serial audio transmitter.
// Assumes: channel-count code is two bits wide.
package mc_audio_tx_pkg;

    // Channel-count code to data words carried by one system word.
    function automatic logic [2:0] words_per_sys(input logic [1:0] chan);
        return {1'b0, chan} + 3'd1;
    endfunction

endpackage

// File: rtl/mc_tx_word_buf.sv
// Module: one-word holding stage between the ready/valid input and the
// serializer. Assumes the consumer only pulls when the stage is full.
module mc_tx_word_buf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] word
);

    assign in_ready = ~full;

    // Capture a word on handshake, release it when the serializer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else begin
            if (take) begin
                full <= 1'b0;
            end
            if (in_valid && in_ready) begin
                full <= 1'b1;
                word <= in_data;
            end
        end
    end

endmodule

// File: rtl/mc_tx_slot_seq.sv
// Module: bit-position sequencer. It tracks the position in the system word
// and the half of the frame. It classifies the next bit as padding or data,
// flags the start of each data slot and drives word select one bit ahead.
// Assumes: configuration is static while running and cfg_sys_len >= packed data.
module mc_tx_slot_seq
    import mc_audio_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [1:0]       cfg_chan,
    input  logic [LEN_W-1:0] cfg_sys_len,
    input  logic             cfg_pad_first,
    output logic             nxt_data,
    output logic             nxt_start,
    output logic             ws_q,
    output logic             pad_q,
    output logic [LEN_W-1:0] pos_q
);

    localparam int WB_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [WB_W-1:0] LAST_BIT = WB_W'(DATA_W - 1);

    logic             half_q;
    logic [WB_W-1:0]  bit_q;
    logic             wrap;
    logic [LEN_W-1:0] nxt_pos;
    logic             nxt_half;
    logic [LEN_W-1:0] last_pos;
    logic [LEN_W-1:0] data_len;
    logic [LEN_W-1:0] data_lo;

    assign last_pos = cfg_sys_len - LEN_W'(1);

    // Next position in the system word and the next frame half.
    always_comb begin
        wrap     = (pos_q >= last_pos);
        nxt_pos  = wrap ? '0 : pos_q + LEN_W'(1);
        nxt_half = wrap ? ~half_q : half_q;
    end

    // Decode the data window and slot starts for the next bit.
    always_comb begin
        data_len  = LEN_W'(DATA_W) * LEN_W'(words_per_sys(cfg_chan));
        data_lo   = cfg_pad_first ? (cfg_sys_len - data_len) : '0;
        nxt_data  = (nxt_pos >= data_lo) && (nxt_pos < data_lo + data_len);
        nxt_start = nxt_data && ((nxt_pos == data_lo) || (bit_q == LAST_BIT));
    end

    // Advance the position and word select on each bit-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= last_pos;
            half_q <= 1'b1;
            ws_q   <= 1'b0;
            pad_q  <= 1'b0;
            bit_q  <= '0;
        end else if (step) begin
            pos_q  <= nxt_pos;
            half_q <= nxt_half;
            ws_q   <= (nxt_pos >= last_pos) ? ~nxt_half : nxt_half;
            pad_q  <= ~nxt_data;
            if (nxt_start) begin
                bit_q <= '0;
            end else if (nxt_data) begin
                bit_q <= bit_q + WB_W'(1);
            end
        end
    end

endmodule

// File: rtl/mc_tx_shifter.sv
// Module: output shifter. It loads a word at each slot start, shifts it out
// MSB first, drives padding bits and records underflow.
// Assumes: step occurs at most once every two system clock cycles.
module mc_tx_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              is_data,
    input  logic              is_start,
    input  logic              pad_val,
    input  logic              word_ok,
    input  logic [DATA_W-1:0] word,
    output logic              take,
    output logic              sd_q,
    output logic              underflow_q
);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] load;

    assign take = step && is_data && is_start && word_ok;
    assign load = word_ok ? word : '0;

    // Drive one serial bit per bit-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q        <= 1'b0;
            sh_q        <= '0;
            underflow_q <= 1'b0;
        end else if (step) begin
            if (!is_data) begin
                sd_q <= pad_val;
            end else if (is_start) begin
                sd_q <= load[DATA_W-1];
                sh_q <= load << 1;
                if (!word_ok) begin
                    underflow_q <= 1'b1;
                end
            end else begin
                sd_q <= sh_q[DATA_W-1];
                sh_q <= sh_q << 1;
            end
        end
    end

endmodule

// File: rtl/mc_audio_tx.sv
// Module: top of the multi-channel serial audio transmitter. It detects
// falling bit-clock edges and connects the holding stage, sequencer and shifter.
// Assumes: bclk is synchronous to clk and at most half its rate.
module mc_audio_tx
    import mc_audio_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic [1:0]        cfg_chan,
    input  logic [LEN_W-1:0]  cfg_sys_len,
    input  logic              cfg_pad_first,
    input  logic              cfg_pad_val,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              ws,
    output logic              sd,
    output logic              underflow
);

    logic              bclk_q;
    logic              step;
    logic              take;
    logic              full;
    logic [DATA_W-1:0] word;
    logic              nxt_data;
    logic              nxt_start;
    logic              pad_q;
    logic [LEN_W-1:0]  pos_q;

    // Remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b1;
        end else begin
            bclk_q <= bclk;
        end
    end

    assign step = rst_n && bclk_q && !bclk;

    mc_tx_word_buf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .take     (take),
        .full     (full),
        .word     (word)
    );

    mc_tx_slot_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .step          (step),
        .cfg_chan      (cfg_chan),
        .cfg_sys_len   (cfg_sys_len),
        .cfg_pad_first (cfg_pad_first),
        .nxt_data      (nxt_data),
        .nxt_start     (nxt_start),
        .ws_q          (ws),
        .pad_q         (pad_q),
        .pos_q         (pos_q)
    );

    mc_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .is_data     (nxt_data),
        .is_start    (nxt_start),
        .pad_val     (cfg_pad_val),
        .word_ok     (full),
        .word        (word),
        .take        (take),
        .sd_q        (sd),
        .underflow_q (underflow)
    );

endmodule

// File: rtl/mc_audio_tx_chk.sv
// Module: assertion checker bound to mc_audio_tx.
// Assumes: the signals named in the bind exist in the top module.
module mc_audio_tx_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             ws,
    input logic             sd,
    input logic             underflow,
    input logic             in_valid,
    input logic             in_ready,
    input logic             cfg_pad_val,
    input logic [LEN_W-1:0] cfg_sys_len,
    input logic             pad_q,
    input logic [LEN_W-1:0] pos_q
);

    // R7: outputs hold whenever the bit clock was high on the previous sample.
    assert_out_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bclk) |-> ($stable(sd) && $stable(ws)));

    // R8: underflow is sticky.
    assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R8: underflow rises only when the holding stage was empty.
    assert_underflow_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(in_ready));

    // R5: a padding bit carries the fill value.
    assert_pad_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_q |-> (sd == cfg_pad_val));

    // R6: word select moves only on the last bit of a system word.
    assert_ws_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> (pos_q >= cfg_sys_len - LEN_W'(1)));

    // R10: an accepted word fills the holding stage.
    assert_hold_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

bind mc_audio_tx mc_audio_tx_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk        (bclk),
    .ws          (ws),
    .sd          (sd),
    .underflow   (underflow),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .cfg_pad_val (cfg_pad_val),
    .cfg_sys_len (cfg_sys_len),
    .pad_q       (pad_q),
    .pos_q       (pos_q)
);

// File: tb/mc_audio_tx_test.sv
// Bench: directed scenarios for mc_audio_tx, one task each, with a
// bit-accurate model of the expected serial stream.
module mc_audio_tx_test;

    localparam int DATA_W = 16;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bclk = 1'b1;
    logic [1:0]        cfg_chan = 2'b00;
    logic [LEN_W-1:0]  cfg_sys_len = 8'd16;
    logic              cfg_pad_first = 1'b0;
    logic              cfg_pad_val = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              ws;
    logic              sd;
    logic              underflow;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] words [0:63];
    int  n_words = 0;
    int  feed_idx = 0;
    bit  feed_rst = 1'b1;
    bit  fire_pending = 1'b0;

    always #2 clk = ~clk;

    mc_audio_tx #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk          (bclk),
        .cfg_chan      (cfg_chan),
        .cfg_sys_len   (cfg_sys_len),
        .cfg_pad_first (cfg_pad_first),
        .cfg_pad_val   (cfg_pad_val),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .ws            (ws),
        .sd            (sd),
        .underflow     (underflow)
    );

    // Feeder: offer words in order on the falling system clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (feed_rst) begin
                feed_idx     = 0;
                fire_pending = 1'b0;
                in_valid     = 1'b0;
                in_data      = '0;
            end else begin
                if (fire_pending) feed_idx++;
                in_valid     = (feed_idx < n_words);
                in_data      = (feed_idx < n_words) ? words[feed_idx] : '0;
                fire_pending = in_valid && in_ready;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Reset, configure, check the reset state and prefill the holding stage.
    task automatic start_case(input logic [1:0] chan, input int len, input bit pf,
                              input bit pv, input int nsup, input int seed);
        feed_rst = 1'b1;
        bclk = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_chan = chan;
        cfg_sys_len = LEN_W'(len);
        cfg_pad_first = pf;
        cfg_pad_val = pv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", ws, 1'b0, "ws after reset");
        check("R9", sd, 1'b0, "sd after reset");
        check("R9", underflow, 1'b0, "underflow after reset");
        check("R9", in_ready, 1'b1, "in_ready after reset");
        for (int i = 0; i < nsup; i++) begin
            words[i] = DATA_W'((i + 1) * 16'h2D63 + seed * 16'h1111) ^ (i[0] ? 16'h8000 : 16'h0000);
        end
        n_words = nsup;
        feed_rst = 1'b0;
        repeat (4) @(negedge clk);
        if (nsup > 0) check("R10", in_ready, 1'b0, "in_ready with held word");
    endtask

    // Drive the bit clock for nsw system words and compare every bit.
    task automatic run_bits(input string req, input int nsw, input int nsup);
        int n  = int'(cfg_chan) + 1;
        int L  = int'(cfg_sys_len);
        int dl = n * DATA_W;
        int lo = cfg_pad_first ? (L - dl) : 0;
        for (int sw = 0; sw < nsw; sw++) begin
            logic h = logic'(sw % 2);
            for (int p = 0; p < L; p++) begin
                logic exp_ws;
                logic exp_sd;
                exp_ws = (p == L - 1) ? ~h : h;
                if (p >= lo && p < lo + dl) begin
                    int k = sw * n + (p - lo) / DATA_W;
                    int b = DATA_W - 1 - ((p - lo) % DATA_W);
                    exp_sd = (k < nsup) ? words[k][b] : 1'b0;
                end else begin
                    exp_sd = cfg_pad_val;
                end
                @(negedge clk);
                bclk = 1'b0;
                repeat (3) @(negedge clk);
                check("R6", ws, exp_ws, $sformatf("ws sw%0d bit%0d", sw, p));
                check(req, sd, exp_sd, $sformatf("sd sw%0d bit%0d", sw, p));
                bclk = 1'b1;
                repeat (2) @(negedge clk);
                check("R7", sd, exp_sd, "sd held while bclk high");
                check("R7", ws, exp_ws, "ws held while bclk high");
            end
        end
    endtask

    // R2 R3: two channels, system word equals one data word.
    task automatic test_two_channel();
        start_case(2'b00, 16, 1'b0, 1'b1, 4, 1);
        run_bits("R1", 4, 4);
        check("R8", underflow, 1'b0, "no underflow in two channel run");
    endtask

    // R2 R3: four channels with no padding.
    task automatic test_four_channel();
        start_case(2'b01, 32, 1'b1, 1'b1, 8, 2);
        run_bits("R3", 4, 8);
        check("R8", underflow, 1'b0, "no underflow in four channel run");
    endtask

    // R4 R5: six channels, padding first and filled high.
    task automatic test_six_pad_first();
        start_case(2'b10, 64, 1'b1, 1'b1, 6, 3);
        run_bits("R4", 2, 6);
        check("R8", underflow, 1'b0, "no underflow in six channel run");
    endtask

    // R2 R4: eight channels, data first, padding low.
    task automatic test_eight_data_first();
        start_case(2'b11, 80, 1'b0, 1'b0, 8, 4);
        run_bits("R2", 2, 8);
    endtask

    // R5: eight channels, data first, padding high.
    task automatic test_eight_pad_high();
        start_case(2'b11, 72, 1'b0, 1'b1, 8, 5);
        run_bits("R5", 2, 8);
    endtask

    // R8: input runs dry mid-frame; remaining slots are zero and flag sticks.
    task automatic test_underflow();
        start_case(2'b01, 40, 1'b0, 1'b1, 5, 6);
        run_bits("R8", 2, 5);
        check("R8", underflow, 1'b0, "no underflow before words run out");
        run_bits_tail();
        check("R8", underflow, 1'b1, "underflow after starvation");
    endtask

    // Continue the underflow case: system words 3 and 4 with words 5..7 missing.
    task automatic run_bits_tail();
        int L = int'(cfg_sys_len);
        for (int sw = 2; sw < 4; sw++) begin
            logic h = logic'(sw % 2);
            for (int p = 0; p < L; p++) begin
                logic exp_sd;
                if (p < 2 * DATA_W) begin
                    int k = sw * 2 + p / DATA_W;
                    exp_sd = (k < 5) ? words[k][DATA_W - 1 - (p % DATA_W)] : 1'b0;
                end else begin
                    exp_sd = 1'b1;
                end
                @(negedge clk);
                bclk = 1'b0;
                repeat (3) @(negedge clk);
                check("R6", ws, (p == L - 1) ? ~h : h, "ws in underflow run");
                check("R8", sd, exp_sd, $sformatf("sd sw%0d bit%0d", sw, p));
                bclk = 1'b1;
                repeat (2) @(negedge clk);
            end
        end
    endtask

    initial begin
        test_two_channel();
        test_four_channel();
        test_six_pad_first();
        test_eight_data_first();
        test_eight_pad_high();
        test_underflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule